// File: doc/BRIEF.md
# Masked-Access GPIO Port

This block is an eight-line general-purpose I/O port on a simple APB-style peripheral bus with byte-wide data. Every pin has its own direction bit, which drives its output enable. Output data is held in a register and driven onto the pad. Reads return the driven value for output pins and a two-flop synchronised pad level for input pins.

The data register is reached through a 256-word window at the bottom of the address space. Address bits [9:2] act as a per-pin mask on every data access. Pin n takes part in a read or write only when address bit n+2 is set. Software can therefore set or clear single pins without a read-modify-write sequence.

The interrupt configuration registers are decoded and stored here, and their values go to a separate sense unit. That unit returns a raw status vector, and this block turns it into raw and masked status reads. A write to the clear register produces a one-cycle clear vector for the sense unit. Every access completes in the access cycle with no wait states.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset, all pins are inputs (`pad_oe` = 0). The output data, direction, sense, both-edges, event and enable registers are all zero.
- R2: The direction register at offset 0x400 can be read and written. Bit n = 1 makes pin n an output, and `pad_oe[n]` equals that bit from the cycle after the write.
- R3: A write at an offset in 0x000–0x3FC changes output data bit n only when address bit n+2 is set. Address bits [1:0] are ignored.
- R4: A data write to a pin that is an input at the time of the write is discarded. That pin keeps its earlier output value when it is later switched to output.
- R5: A data read returns zero in every bit whose address mask bit is clear. A masked output pin returns its driven data. A masked input pin returns the pad level delayed by two clock edges.
- R6: `pad_out` always equals the output data register.
- R7: The sense (0x404), both-edges (0x408), event (0x40C) and enable (0x410) registers can be read and written, and each appears on its own configuration output.
- R8: Offset 0x414 reads `raw_status`, and offset 0x418 reads `raw_status` AND enable. Writes to both offsets are ignored.
- R9: A write to 0x41C drives `irq_clear` with the write data during the access cycle only. At all other times `irq_clear` is zero, and a read of 0x41C returns zero.
- R10: `pready` is always 1. Offsets above 0x41C and below 0x1000 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid in the access phase |
| pready | output | 1 | Always ready |
| pad_in | input | 8 | Pad levels (asynchronous) |
| pad_out | output | 8 | Output data to pads |
| pad_oe | output | 8 | Per-pin output enable |
| pin_level | output | 8 | Synchronised pad levels for the sense unit |
| cfg_sense | output | 8 | Level/edge select per pin |
| cfg_both | output | 8 | Both-edge select per pin |
| cfg_event | output | 8 | Polarity/edge select per pin |
| cfg_enable | output | 8 | Interrupt enable per pin |
| raw_status | input | 8 | Raw interrupt status from the sense unit |
| irq_clear | output | 8 | One-cycle clear vector to the sense unit |

## Verification
The assertions check the following on every cycle:
- Output data never changes on a pin that was an input, or whose mask bit was clear, in the previous cycle.
- Output enables change only after a direction write.
- The clear vector is nonzero only during a clear-register write.
- Unused offsets and the clear register read as zero.

Other behaviour needs the bench scenarios:
- The two-edge delay on input reads.
- The discarded write that reappears when a pin turns to output.
- Mixed reads that combine driven and sampled bits.
- The enable mask applied to status.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Register selected by the current bus address
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_SENSE,
        SEL_BOTH,
        SEL_EVENT,
        SEL_ENABLE,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLEAR
    } reg_sel_e;

    // Word indices (byte offset >> 2) of the control registers
    localparam logic [9:0] W_DIR    = 10'h100;
    localparam logic [9:0] W_SENSE  = 10'h101;
    localparam logic [9:0] W_BOTH   = 10'h102;
    localparam logic [9:0] W_EVENT  = 10'h103;
    localparam logic [9:0] W_ENABLE = 10'h104;
    localparam logic [9:0] W_RAW    = 10'h105;
    localparam logic [9:0] W_MASKED = 10'h106;
    localparam logic [9:0] W_CLEAR  = 10'h107;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS   = 8,
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o,
    output logic [PINS-1:0]   mask_o
);
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned WIN_LO = PINS + 2;

    logic [WORD_W-1:0] word;
    assign word   = addr_i[ADDR_W-1:2];
    assign mask_o = addr_i[PINS+1:2];

    always_comb begin
        sel_o = SEL_NONE;
        if (addr_i[ADDR_W-1:WIN_LO] == '0) begin
            sel_o = SEL_DATA;
        end else begin
            unique case (word)
                WORD_W'(W_DIR):    sel_o = SEL_DIR;
                WORD_W'(W_SENSE):  sel_o = SEL_SENSE;
                WORD_W'(W_BOTH):   sel_o = SEL_BOTH;
                WORD_W'(W_EVENT):  sel_o = SEL_EVENT;
                WORD_W'(W_ENABLE): sel_o = SEL_ENABLE;
                WORD_W'(W_RAW):    sel_o = SEL_RAW;
                WORD_W'(W_MASKED): sel_o = SEL_MASKED;
                WORD_W'(W_CLEAR):  sel_o = SEL_CLEAR;
                default:           sel_o = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input  reg_sel_e        sel_i,
    input  logic [PINS-1:0] mask_i,
    input  logic [PINS-1:0] dir_i,
    input  logic [PINS-1:0] data_i,
    input  logic [PINS-1:0] level_i,
    input  logic [PINS-1:0] sense_i,
    input  logic [PINS-1:0] both_i,
    input  logic [PINS-1:0] event_i,
    input  logic [PINS-1:0] enable_i,
    input  logic [PINS-1:0] raw_i,
    output logic [PINS-1:0] rdata_o
);
    logic [PINS-1:0] pin_view;

    // Per pin: driven value when output, sampled pad when input
    for (genvar p = 0; p < PINS; p++) begin : g_view
        assign pin_view[p] = dir_i[p] ? data_i[p] : level_i[p];
    end

    always_comb begin
        unique case (sel_i)
            SEL_DATA:   rdata_o = pin_view & mask_i;
            SEL_DIR:    rdata_o = dir_i;
            SEL_SENSE:  rdata_o = sense_i;
            SEL_BOTH:   rdata_o = both_i;
            SEL_EVENT:  rdata_o = event_i;
            SEL_ENABLE: rdata_o = enable_i;
            SEL_RAW:    rdata_o = raw_i;
            SEL_MASKED: rdata_o = raw_i & enable_i;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS   = 8,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [PINS-1:0]   pwdata,
    output logic [PINS-1:0]   prdata,
    output logic              pready,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pin_level,
    output logic [PINS-1:0]   cfg_sense,
    output logic [PINS-1:0]   cfg_both,
    output logic [PINS-1:0]   cfg_event,
    output logic [PINS-1:0]   cfg_enable,
    input  logic [PINS-1:0]   raw_status,
    output logic [PINS-1:0]   irq_clear
);
    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] data;
        logic [PINS-1:0] sense;
        logic [PINS-1:0] both;
        logic [PINS-1:0] evt;
        logic [PINS-1:0] enable;
    } port_state_t;

    port_state_t     st_d, st_q;
    reg_sel_e        sel;
    logic [PINS-1:0] addr_mask;
    logic [PINS-1:0] level;
    logic            wr_en;
    logic [PINS-1:0] data_wmask;

    gpio_decode #(.PINS(PINS), .ADDR_W(ADDR_W)) u_decode (
        .addr_i (paddr),
        .sel_o  (sel),
        .mask_o (addr_mask)
    );

    gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (level)
    );

    assign wr_en      = psel && penable && pwrite;
    // Only pins that are outputs now and selected by the address take data
    assign data_wmask = addr_mask & st_q.dir;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (sel)
                SEL_DATA:   st_d.data   = (st_q.data & ~data_wmask) | (pwdata & data_wmask);
                SEL_DIR:    st_d.dir    = pwdata;
                SEL_SENSE:  st_d.sense  = pwdata;
                SEL_BOTH:   st_d.both   = pwdata;
                SEL_EVENT:  st_d.evt    = pwdata;
                SEL_ENABLE: st_d.enable = pwdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    gpio_rdmux #(.PINS(PINS)) u_rdmux (
        .sel_i    (sel),
        .mask_i   (addr_mask),
        .dir_i    (st_q.dir),
        .data_i   (st_q.data),
        .level_i  (level),
        .sense_i  (st_q.sense),
        .both_i   (st_q.both),
        .event_i  (st_q.evt),
        .enable_i (st_q.enable),
        .raw_i    (raw_status),
        .rdata_o  (prdata)
    );

    assign pready     = 1'b1;
    assign pad_out    = st_q.data;
    assign pad_oe     = st_q.dir;
    assign pin_level  = level;
    assign cfg_sense  = st_q.sense;
    assign cfg_both   = st_q.both;
    assign cfg_event  = st_q.evt;
    assign cfg_enable = st_q.enable;
    assign irq_clear  = (wr_en && sel == SEL_CLEAR) ? pwdata : '0;
endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
    parameter int unsigned PINS   = 8,
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [PINS-1:0]   pwdata,
    input logic [PINS-1:0]   prdata,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   irq_clear
);
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] DIR_WORD   = WORD_W'(10'h100);
    localparam logic [WORD_W-1:0] CLEAR_WORD = WORD_W'(10'h107);

    logic              acc_wr;
    logic              acc_rd;
    logic [WORD_W-1:0] word;
    assign acc_wr = psel && penable && pwrite;
    assign acc_rd = psel && penable && !pwrite;
    assign word   = paddr[ADDR_W-1:2];

    // R1: while reset is held, no pin is enabled or driven
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (pad_oe == '0 && pad_out == '0));

    // R2: output enables move only after a direction write
    a_r2_oe_needs_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pad_oe) |-> $past(acc_wr && word == DIR_WORD));

    // R3: output data changes only on pins selected by the previous address mask
    a_r3_mask_limits_write: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ $past(pad_out)) & ~$past(paddr[PINS+1:2])) == '0));

    // R4: a pin that was an input keeps its output data value
    a_r4_input_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0));

    // R9: clear vector appears only during a clear-register write
    a_r9_clear_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear != '0) |-> (acc_wr && word == CLEAR_WORD));

    // R9 and R10: clear register and offsets above it read as zero
    a_r10_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && word >= CLEAR_WORD && paddr[ADDR_W-1:PINS+2] != '0) |-> (prdata == '0));
endmodule

bind gpio_masked_port gpio_masked_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_clear (irq_clear)
);

// File: tb/sim_gpio_masked_port.sv
module sim_gpio_masked_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [7:0]  pwdata = '0;
    logic [7:0]  prdata;
    logic        pready;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, pin_level;
    logic [7:0]  cfg_sense, cfg_both, cfg_event, cfg_enable;
    logic [7:0]  raw_status = '0;
    logic [7:0]  irq_clear;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    gpio_masked_port u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_level(pin_level),
        .cfg_sense(cfg_sense), .cfg_both(cfg_both), .cfg_event(cfg_event),
        .cfg_enable(cfg_enable), .raw_status(raw_status), .irq_clear(irq_clear)
    );

    // Behavioural reference model
    int        m_dir, m_data, m_sense, m_both, m_event, m_enable;
    int        pad_pipe [$];

    function automatic int model_level();
        return (pad_pipe.size() >= 2) ? pad_pipe[pad_pipe.size()-2] : 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir <= 0; m_data <= 0; m_sense <= 0; m_both <= 0; m_event <= 0; m_enable <= 0;
            pad_pipe.delete();
        end else begin
            pad_pipe.push_back(int'(pad_in));
            if (pad_pipe.size() > 2) void'(pad_pipe.pop_front());
            if (psel && penable && pwrite) begin
                int a;
                a = int'(paddr);
                if (a < 'h400) begin
                    int sel;
                    sel = (a >> 2) & 'hFF & m_dir;
                    m_data <= (m_data & ~sel) | (int'(pwdata) & sel);
                end
                else if ((a >> 2) == ('h400 >> 2)) m_dir    <= int'(pwdata);
                else if ((a >> 2) == ('h404 >> 2)) m_sense  <= int'(pwdata);
                else if ((a >> 2) == ('h408 >> 2)) m_both   <= int'(pwdata);
                else if ((a >> 2) == ('h40C >> 2)) m_event  <= int'(pwdata);
                else if ((a >> 2) == ('h410 >> 2)) m_enable <= int'(pwdata);
            end
        end
    end

    function automatic int model_read(int a);
        int w;
        w = a >> 2;
        if (a < 'h400) begin
            int view;
            view = (m_dir & m_data) | (~m_dir & model_level());
            return view & (w & 'hFF) & 'hFF;
        end
        case (w)
            'h100: return m_dir;
            'h101: return m_sense;
            'h102: return m_both;
            'h103: return m_event;
            'h104: return m_enable;
            'h105: return int'(raw_status);
            'h106: return int'(raw_status) & m_enable;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // Compare every cycle against the model
    always begin
        @(negedge clk);
        #2;
        if (rst_n && !finished) begin
            int exp_clr;
            exp_clr = (psel && penable && pwrite && (paddr >> 2) == ('h41C >> 2)) ? int'(pwdata) : 0;
            chk("R6 pad_out", int'(pad_out), m_data);
            chk("R2 pad_oe", int'(pad_oe), m_dir);
            chk("R7 cfg", {cfg_sense, cfg_both, cfg_event, cfg_enable},
                {m_sense[7:0], m_both[7:0], m_event[7:0], m_enable[7:0]});
            chk("R9 irq_clear", int'(irq_clear), exp_clr);
            chk("R10 pready", int'(pready), 1);
        end
    end

    task automatic bus(input bit wr, input int a, input int wd, output int rd);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = 12'(a); pwdata = 8'(wd);
        @(negedge clk);
        penable = 1'b1;
        #1 rd = int'(prdata);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input int a, input int wd);
        int dummy;
        bus(1'b1, a, wd, dummy);
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        int got;
        bus(1'b0, a, 0, got);
        chk(tag, got, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 oe after reset", int'(pad_oe), 0);
        chk("R1 out after reset", int'(pad_out), 0);
        rd_chk("R1 dir reads 0", 'h400, 0);
        rd_chk("R1 enable reads 0", 'h410, 0);

        // R5: input pins, two-edge latency then full and partial masks
        pad_in = 8'hA5;
        @(negedge clk);
        #2 chk("R5 not yet sampled", int'(pin_level), 0);
        @(negedge clk);
        #2 chk("R5 sampled after two edges", int'(pin_level), 'hA5);
        rd_chk("R5 full mask read", 'h3FC, 'hA5);
        rd_chk("R5 low nibble mask", 'h03C, 'h05);
        rd_chk("R5 zero mask", 'h000, 0);

        // R4: write while every pin is input is discarded
        wr('h3FC, 'hFF);
        chk("R4 input write dropped", int'(pad_out), 0);

        // R2: direction
        wr('h400, 'h0F);
        rd_chk("R2 dir readback", 'h400, 'h0F);
        chk("R2 oe follows dir", int'(pad_oe), 'h0F);

        // R3: mask 0x03 via address 0x00C, low address bits ignored
        wr('h00F, 'hFF);
        chk("R3 masked write", int'(pad_out), 'h03);
        rd_chk("R5 mixed read", 'h3FC, model_read('h3FC));
        rd_chk("R5 mixed read value", 'h3FC, 'hA3);

        // R4: pin 4 to output keeps old zero
        wr('h400, 'h1F);
        chk("R4 pin4 keeps old value", int'(pad_out), 'h03);
        wr('h040, 'h10);
        chk("R3 single pin set", int'(pad_out), 'h13);
        wr('h3FC, 'h00);
        chk("R3 clear outputs only", int'(pad_out), 'h00);

        // R7: interrupt configuration
        wr('h404, 'h11); wr('h408, 'h22); wr('h40C, 'h44); wr('h410, 'h0F);
        rd_chk("R7 sense", 'h404, 'h11);
        rd_chk("R7 both", 'h408, 'h22);
        rd_chk("R7 event", 'h40C, 'h44);
        rd_chk("R7 enable", 'h410, 'h0F);

        // R8: status
        raw_status = 8'h3C;
        rd_chk("R8 raw", 'h414, 'h3C);
        rd_chk("R8 masked", 'h418, 'h0C);
        wr('h414, 'hFF); wr('h418, 'hFF);
        rd_chk("R8 enable untouched", 'h410, 'h0F);
        rd_chk("R8 dir untouched", 'h400, 'h1F);

        // R9: clear
        wr('h41C, 'h81);
        rd_chk("R9 clear reads 0", 'h41C, 0);

        // R10: unused offsets
        wr('h420, 'hFF); wr('hFFC, 'hFF);
        rd_chk("R10 0x420 reads 0", 'h420, 0);
        rd_chk("R10 0xFFC reads 0", 'hFFC, 0);
        rd_chk("R10 dir unchanged", 'h400, 'h1F);
        chk("R10 data unchanged", int'(pad_out), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule